// File: doc/BRIEF.md
# Bus Hold Arbitration Controller

This block lets the external bus of a chip be shared with a second bus master through a three-wire handshake: an active-low hold input, an active-low acknowledge line and an active-low bus request output. After reset it leaves all three pins to their general-purpose logic. It takes them over only once software sets the enable input. From then on it runs the handshake without software involvement.

A single controller covers both roles, and a mode input picks the role. As master, which is the default, it drives the acknowledge line. It honours a hold request from the other device once the cycle engine reports the bus idle. It then floats the bus, acknowledges one clock later, and asks for the bus back when an external access of its own is waiting. As slave, the acknowledge line becomes an input. The controller requests the bus, keeps it floated until the grant arrives, and gives it back when it has nothing left to do. Because the acknowledge line changes direction with the role, two of these controllers connect pin to pin without extra logic. The hold and acknowledge inputs pass through a synchronizer of parameterised depth before they are used. Software is expected to change the mode only while arbitration is disabled.

Top module: `holdArbiter`

## Requirements
- R1: While arbEnable is 0, both output enables are 0, busFloat is 0, and hldaOutN and breqOutN are 1, whatever the other inputs do. One clock after arbEnable goes to 0, the outputs are in this state.
- R2: Master mode (slaveMode = 0) with arbitration enabled drives the acknowledge pin (hldaOe = 1) and the request pin (breqOe = 1). Before any hold request, the bus is driven (busFloat = 0).
- R3: Slave mode (slaveMode = 1) with arbitration enabled leaves the acknowledge pin as an input (hldaOe = 0) and drives the request pin (breqOe = 1). The bus is floated (busFloat = 1) until a grant is received.
- R4: In master mode, a hold request (holdInN = 0) does not float the bus while busIdle is 0. It is granted once busIdle is 1.
- R5: In master mode, when a hold request is granted, busFloat rises first and hldaOutN falls exactly one clock later.
- R6: In master mode, when holdInN returns to 1, hldaOutN rises first and busFloat falls exactly one clock later.
- R7: In master mode, breqOutN is 0 only while hldaOutN is 0 and extReqPending is 1. An access that is pending while the bus is still driven leaves breqOutN at 1.
- R8: In slave mode, extReqPending = 1 makes breqOutN 0. The bus stays floated while hldaInN is 1, and it is driven after hldaInN goes to 0.
- R9: In slave mode, the bus is given back only when extReqPending is 0 and busIdle is 1. busFloat rises first and breqOutN returns to 1 exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| arbEnable | input | 1 | Software enable for arbitration |
| slaveMode | input | 1 | 0 selects master role, 1 selects slave role |
| busIdle | input | 1 | Cycle engine reports no bus cycle in progress |
| extReqPending | input | 1 | An internal external-bus access is waiting |
| holdInN | input | 1 | Hold request pin, active low |
| hldaInN | input | 1 | Acknowledge pin as input (slave grant), active low |
| hldaOutN | output | 1 | Acknowledge pin output value, active low |
| hldaOe | output | 1 | Output enable of the acknowledge pin |
| breqOutN | output | 1 | Bus request pin output value, active low |
| breqOe | output | 1 | Output enable of the bus request pin |
| busFloat | output | 1 | 1 tells the bus interface to float address, data and control |

## Verification
The bench builds the block with the default synchronizer depth of two stages. At that depth, a pin change reaches the state machine three clocks after it is driven. The drain windows in the bench are wide enough for any depth up to about thirty stages. The ordering gaps the bench checks, float before acknowledge and acknowledge off before drive, are one clock at every depth. They are therefore exercised in full. The handover into slave mode and the return to master mode both occur within the bench, through the disabled state.

// File: rtl/holdArbPkg.sv
package holdArbPkg;

  typedef enum logic [3:0] {
    ST_OFF,
    M_OWN,
    M_FLOAT,
    M_GRANT,
    M_UNACK,
    S_IDLE,
    S_REQ,
    S_OWN,
    S_DROP
  } arbState_t;

  typedef struct packed {
    logic pinsOwned;
    logic ackDrive;
    logic ackOn;
    logic reqOn;
    logic floatBus;
  } arbStrobe_t;

endpackage

// File: rtl/holdArbCtrl.sv
module holdArbCtrl
  import holdArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       arbEnable,
  input  logic       slaveMode,
  input  logic       busIdle,
  input  logic       extReqPending,
  input  logic       holdReq,
  input  logic       ackIn,
  output arbStrobe_t strobe
);

  arbState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    if (!arbEnable) begin
      nextState = ST_OFF;
    end else begin
      case (state)
        ST_OFF:  nextState = slaveMode ? S_IDLE : M_OWN;
        M_OWN:   if (holdReq && busIdle) nextState = M_FLOAT;
        M_FLOAT: nextState = M_GRANT;
        M_GRANT: if (!holdReq) nextState = M_UNACK;
        M_UNACK: nextState = M_OWN;
        S_IDLE:  if (extReqPending) nextState = S_REQ;
        S_REQ:   if (ackIn) nextState = S_OWN;
        S_OWN:   if (!extReqPending && busIdle) nextState = S_DROP;
        S_DROP:  nextState = S_IDLE;
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    case (state)
      M_OWN:   begin strobe.pinsOwned = 1'b1; strobe.ackDrive = 1'b1; end
      M_FLOAT: begin strobe.pinsOwned = 1'b1; strobe.ackDrive = 1'b1; strobe.floatBus = 1'b1; end
      M_GRANT: begin
        strobe.pinsOwned = 1'b1;
        strobe.ackDrive  = 1'b1;
        strobe.floatBus  = 1'b1;
        strobe.ackOn     = 1'b1;
        strobe.reqOn     = extReqPending;
      end
      M_UNACK: begin strobe.pinsOwned = 1'b1; strobe.ackDrive = 1'b1; strobe.floatBus = 1'b1; end
      S_IDLE:  begin strobe.pinsOwned = 1'b1; strobe.floatBus = 1'b1; end
      S_REQ:   begin strobe.pinsOwned = 1'b1; strobe.floatBus = 1'b1; strobe.reqOn = 1'b1; end
      S_OWN:   begin strobe.pinsOwned = 1'b1; strobe.reqOn = 1'b1; end
      S_DROP:  begin strobe.pinsOwned = 1'b1; strobe.floatBus = 1'b1; strobe.reqOn = 1'b1; end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/holdArbPins.sv
module holdArbPins
  import holdArbPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdInN,
  input  logic       hldaInN,
  input  arbStrobe_t strobe,
  output logic       holdReq,
  output logic       ackIn,
  output logic       hldaOutN,
  output logic       hldaOe,
  output logic       breqOutN,
  output logic       breqOe,
  output logic       busFloat
);

  localparam int NUM_SYNC = 2;

  logic [NUM_SYNC-1:0] pinIn;
  logic [NUM_SYNC-1:0] pinSync;

  assign pinIn = {hldaInN, holdInN};

  for (genvar p = 0; p < NUM_SYNC; p++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= SYNC_STAGES'({chain, pinIn[p]});
    end
    assign pinSync[p] = chain[SYNC_STAGES-1];
  end

  assign holdReq  = ~pinSync[0];
  assign ackIn    = ~pinSync[1];

  assign hldaOe   = strobe.pinsOwned & strobe.ackDrive;
  assign breqOe   = strobe.pinsOwned;
  assign hldaOutN = ~strobe.ackOn;
  assign breqOutN = ~strobe.reqOn;
  assign busFloat = strobe.floatBus;

endmodule

// File: rtl/holdArbiter.sv
module holdArbiter
  import holdArbPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic arbEnable,
  input  logic slaveMode,
  input  logic busIdle,
  input  logic extReqPending,
  input  logic holdInN,
  input  logic hldaInN,
  output logic hldaOutN,
  output logic hldaOe,
  output logic breqOutN,
  output logic breqOe,
  output logic busFloat
);

  arbStrobe_t strobe;
  logic       holdReq;
  logic       ackIn;

  holdArbCtrl i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .arbEnable     (arbEnable),
    .slaveMode     (slaveMode),
    .busIdle       (busIdle),
    .extReqPending (extReqPending),
    .holdReq       (holdReq),
    .ackIn         (ackIn),
    .strobe        (strobe)
  );

  holdArbPins #(.SYNC_STAGES(SYNC_STAGES)) i_pins (
    .clk      (clk),
    .rstN     (rstN),
    .holdInN  (holdInN),
    .hldaInN  (hldaInN),
    .strobe   (strobe),
    .holdReq  (holdReq),
    .ackIn    (ackIn),
    .hldaOutN (hldaOutN),
    .hldaOe   (hldaOe),
    .breqOutN (breqOutN),
    .breqOe   (breqOe),
    .busFloat (busFloat)
  );

endmodule

// File: rtl/holdArbChecker.sv
module holdArbChecker (
  input logic clk,
  input logic rstN,
  input logic arbEnable,
  input logic busIdle,
  input logic extReqPending,
  input logic hldaOutN,
  input logic hldaOe,
  input logic breqOutN,
  input logic breqOe,
  input logic busFloat
);

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !arbEnable |=> (!hldaOe && !breqOe && !busFloat && hldaOutN && breqOutN));

  assert_grant_when_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busFloat) && hldaOe && $past(hldaOe)) |-> $past(busIdle));

  assert_float_before_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hldaOutN) |-> ($past(busFloat) && busFloat));

  assert_ack_off_before_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busFloat) && hldaOe) |-> $past(hldaOutN));

  assert_master_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!breqOutN && hldaOe) |-> (!hldaOutN && extReqPending));

  assert_slave_owns_with_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (breqOe && !hldaOe && !busFloat) |-> !breqOutN);

  assert_slave_float_before_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(breqOutN) && breqOe && !hldaOe) |-> ($past(busFloat) && busFloat));

endmodule

bind holdArbiter holdArbChecker i_holdArbChecker (
  .clk           (clk),
  .rstN          (rstN),
  .arbEnable     (arbEnable),
  .busIdle       (busIdle),
  .extReqPending (extReqPending),
  .hldaOutN      (hldaOutN),
  .hldaOe        (hldaOe),
  .breqOutN      (breqOutN),
  .breqOe        (breqOe),
  .busFloat      (busFloat)
);

// File: tb/test_holdArbiter.sv
`timescale 1ns/1ps
module test_holdArbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arbEnable = 1'b0;
  logic slaveMode = 1'b0;
  logic busIdle = 1'b1;
  logic extReqPending = 1'b0;
  logic holdInN = 1'b1;
  logic hldaInN = 1'b1;
  logic hldaOutN, hldaOe, breqOutN, breqOe, busFloat;

  always #2.5 clk = ~clk;

  holdArbiter i_holdArbiter (
    .clk(clk), .rstN(rstN), .arbEnable(arbEnable), .slaveMode(slaveMode),
    .busIdle(busIdle), .extReqPending(extReqPending), .holdInN(holdInN),
    .hldaInN(hldaInN), .hldaOutN(hldaOutN), .hldaOe(hldaOe),
    .breqOutN(breqOutN), .breqOe(breqOe), .busFloat(busFloat)
  );

  // bundle bit order: {busFloat, hldaOutN, hldaOe, breqOutN, breqOe}
  typedef struct {
    logic [4:0] bits;
    int         gap;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastChange = 0;
  logic [4:0] lastObs = 5'b01010;
  bit finished = 0;

  function automatic logic [4:0] bundle();
    return {busFloat, hldaOutN, hldaOe, breqOutN, breqOe};
  endfunction

  // monitor: pops one expected item per observed output change
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (rstN && bundle() != lastObs) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R4/R8 unexpected change: actual %b expected %b (no change)", bundle(), lastObs);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          if (bundle() !== e.bits) begin
            errors++;
            $display("FAIL %s outputs: actual %b expected %b", e.tag, bundle(), e.bits);
          end
          if (e.gap != 0) begin
            checks++;
            if (cyc - lastChange != e.gap) begin
              errors++;
              $display("FAIL %s gap: actual %0d expected %0d", e.tag, cyc - lastChange, e.gap);
            end
          end
        end
        lastChange = cyc;
        lastObs = bundle();
      end
    end
  end

  task automatic expectChange(input logic [4:0] bits, input int gap, input string tag);
    expItem_t e;
    e.bits = bits;
    e.gap = gap;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 40 && expQ.size() != 0; i++) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s missing change: actual %b expected %b", tag, bundle(), expQ[0].bits);
      expQ.delete();
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic directCheck(input logic [4:0] exp, input string tag);
    checks++;
    if (bundle() !== exp) begin
      errors++;
      $display("FAIL %s direct: actual %b expected %b", tag, bundle(), exp);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    directCheck(5'b01010, "R1 reset");

    // R1: hold pin ignored while disabled
    holdInN = 1'b0;
    repeat (8) @(negedge clk);
    directCheck(5'b01010, "R1 disabled ignores hold");
    holdInN = 1'b1;
    repeat (4) @(negedge clk);

    // R2: enable master
    expectChange(5'b01111, 0, "R2");
    arbEnable = 1'b1;
    drain("R2");

    // R7: pending access while bus still driven leaves request off
    extReqPending = 1'b1;
    repeat (5) @(negedge clk);
    extReqPending = 1'b0;
    @(negedge clk);

    // R4: hold while bus busy, then idle
    busIdle = 1'b0;
    holdInN = 1'b0;
    repeat (10) @(negedge clk);
    expectChange(5'b11111, 0, "R4");
    expectChange(5'b10111, 1, "R5");
    busIdle = 1'b1;
    drain("R5");

    // R7: request bus back while granted
    expectChange(5'b10101, 0, "R7");
    extReqPending = 1'b1;
    drain("R7");
    expectChange(5'b10111, 0, "R7");
    extReqPending = 1'b0;
    drain("R7");

    // R6: release hold
    expectChange(5'b11111, 0, "R6");
    expectChange(5'b01111, 1, "R6");
    holdInN = 1'b1;
    drain("R6");

    // R1: disable
    expectChange(5'b01010, 0, "R1");
    arbEnable = 1'b0;
    drain("R1");

    // R3: slave mode
    slaveMode = 1'b1;
    expectChange(5'b11011, 0, "R3");
    arbEnable = 1'b1;
    drain("R3");

    // R8: request, wait for grant
    expectChange(5'b11001, 0, "R8");
    extReqPending = 1'b1;
    drain("R8");
    repeat (8) @(negedge clk);
    expectChange(5'b01001, 0, "R8");
    hldaInN = 1'b0;
    drain("R8");

    // R9: no release while busy, then float and drop request
    busIdle = 1'b0;
    extReqPending = 1'b0;
    repeat (6) @(negedge clk);
    expectChange(5'b11001, 0, "R9");
    expectChange(5'b11011, 1, "R9");
    busIdle = 1'b1;
    drain("R9");
    hldaInN = 1'b1;
    repeat (4) @(negedge clk);

    // R1: disable from slave, then back to master
    expectChange(5'b01010, 0, "R1");
    arbEnable = 1'b0;
    drain("R1");
    slaveMode = 1'b0;
    expectChange(5'b01111, 0, "R2");
    arbEnable = 1'b1;
    drain("R2");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule